// File: doc/BRIEF.md
# USB Host Interrupt Enable and Status Controller

This block is the interrupt front end of a USB host controller. A single enable store is reached through two register addresses. Writing ones at the set address turns the selected enables on. Writing ones at the clear address turns them off. Zero bits have no effect at either address, and a read at either address returns the enable store. A status register captures single-cycle event pulses from the host core. Software clears a status bit by writing 1 to it.

One interrupt line is driven from the two registers. It is asserted when the master enable is on and at least one status bit is set whose own enable is also on. A hardware reset and a synchronous software reset both return the enable store to master-on with every source off, and both clear the status register.

The register port is a plain 32-bit interface: address, write strobe, write data, and a combinational read data output. The byte offsets are 0x0 for status, 0x4 for the enable-set alias and 0x8 for the enable-clear alias.

Top module: `usbh_irq_ctrl`

## Requirements
- R1: After hardware reset, the enable store reads 0x8000_0000, the status register reads 0, and `irq` is low.
- R2: A write to offset 0x8 clears every enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R3: A write to offset 0x4 sets every valid enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R4: A read at offset 0x4 and a read at offset 0x8 both return the current enable store.
- R5: Only these bit positions are implemented: master enable at 31, ownership change at 30, root hub status change at 6, frame number overflow at 5, unrecoverable error at 4, resume detect at 3, start of frame at 2, and done-head writeback at 1. Every other bit reads 0 in both registers, and writes or events on those bits have no effect. Status bit 31 is always 0.
- R6: An `evt_in` pulse on a source bit sets the status bit at the same position, readable at offset 0x0 on the next cycle. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R7: If an event and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R8: While the master enable is 1, `irq` is high exactly when some status bit and the enable bit at the same position are both 1.
- R9: While the master enable is 0, `irq` stays low whatever the status and the source enables hold.
- R10: A one-cycle `soft_rst` pulse returns the enable store to 0x8000_0000 and the status register to 0 on the next clock edge.
- R11: Reads at any other offset return 0, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous software reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| evt_in | input | 32 | Single-cycle event pulses, one per status bit position |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is an event pulse and a write-1-to-clear landing on the same status bit in the same clock cycle. The bench reaches it by raising `evt_in` and the status write strobe on the same falling edge, then reading the status back.

Gating by the master enable is also hard to see, because a pending, individually enabled source must exist first. The bench builds that state with an event and a set-alias write. It then drops and restores bit 31 through the two aliases while `irq` is watched.

// File: rtl/usbh_irq_pkg.sv
package usbh_irq_pkg;
  localparam int unsigned DATA_W = 32;

  // bit positions; consumers decode these, so they are fixed
  localparam int unsigned POS_MASTER  = 31;
  localparam int unsigned POS_OWNCHG  = 30;
  localparam int unsigned POS_HUBCHG  = 6;
  localparam int unsigned POS_FRMOVF  = 5;
  localparam int unsigned POS_FATAL   = 4;
  localparam int unsigned POS_RESUME  = 3;
  localparam int unsigned POS_SOF     = 2;
  localparam int unsigned POS_DONEHD  = 1;

  localparam int unsigned NUM_SRC = 7;

  typedef logic [DATA_W-1:0] word_t;

  function automatic word_t src_mask();
    word_t m;
    m = '0;
    m[POS_OWNCHG] = 1'b1;
    m[POS_HUBCHG] = 1'b1;
    m[POS_FRMOVF] = 1'b1;
    m[POS_FATAL]  = 1'b1;
    m[POS_RESUME] = 1'b1;
    m[POS_SOF]    = 1'b1;
    m[POS_DONEHD] = 1'b1;
    return m;
  endfunction

  function automatic word_t en_mask();
    word_t m;
    m = src_mask();
    m[POS_MASTER] = 1'b1;
    return m;
  endfunction

  function automatic word_t en_reset_val();
    word_t m;
    m = '0;
    m[POS_MASTER] = 1'b1;
    return m;
  endfunction

  // enable store update: set alias ORs in, clear alias masks out
  function automatic word_t en_update(word_t cur, logic set_we, logic clr_we, word_t wd);
    word_t nxt;
    nxt = cur;
    if (set_we) nxt = nxt | wd;
    if (clr_we) nxt = nxt & ~wd;
    return nxt & en_mask();
  endfunction

  // status update: write-1-clear first, then events override
  function automatic word_t st_update(word_t cur, logic w1c_we, word_t wd, word_t evt);
    word_t nxt;
    nxt = cur;
    if (w1c_we) nxt = nxt & ~wd;
    nxt = nxt | evt;
    return nxt & src_mask();
  endfunction

  function automatic logic irq_eval(word_t st, word_t en);
    return en[POS_MASTER] & (|(st & en & src_mask()));
  endfunction
endpackage

// File: rtl/usbh_irq_enable_store.sv
module usbh_irq_enable_store
  import usbh_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  soft_rst,
  input  logic  set_we,
  input  logic  clr_we,
  input  word_t wdata,
  output word_t en_q
);
  localparam word_t MASK  = en_mask();
  localparam word_t RSTV  = en_reset_val();

  word_t en_d;
  assign en_d = en_update(en_q, set_we, clr_we, wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= RSTV;
    else if (soft_rst) en_q <= RSTV;
    else               en_q <= en_d;
  end

  // R3
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_we && !soft_rst) |=> ((en_q & $past(wdata) & MASK) == ($past(wdata) & MASK)));

  // R2
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we && !soft_rst) |=> ((en_q & $past(wdata)) == '0));

  // R2
  clr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we && !soft_rst) |=> ((en_q & ~$past(wdata)) == ($past(en_q) & ~$past(wdata))));

  // R5
  en_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & ~MASK) == '0);

  // R10
  en_srst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (en_q == RSTV));
endmodule

// File: rtl/usbh_irq_status_reg.sv
module usbh_irq_status_reg
  import usbh_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  soft_rst,
  input  logic  w1c_we,
  input  word_t wdata,
  input  word_t evt,
  output word_t st_q
);
  localparam word_t SRC = src_mask();

  word_t st_d;
  word_t evt_hit;
  assign st_d    = st_update(st_q, w1c_we, wdata, evt);
  assign evt_hit = evt & SRC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        st_q <= '0;
    else if (soft_rst) st_q <= '0;
    else               st_q <= st_d;
  end

  // R6 R7
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_hit != '0 && !soft_rst) |=> ((st_q & $past(evt_hit)) == $past(evt_hit)));

  // R6
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c_we && !soft_rst) |=> ((st_q & $past(wdata) & ~$past(evt)) == '0));

  // R5
  st_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q & ~SRC) == '0);

  // R10
  st_srst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (st_q == '0));
endmodule

// File: rtl/usbh_irq_gate.sv
module usbh_irq_gate
  import usbh_irq_pkg::*;
(
  input  word_t st,
  input  word_t en,
  output logic  irq
);
  assign irq = irq_eval(st, en);
endmodule

// File: rtl/usbh_irq_ctrl.sv
module usbh_irq_ctrl
  import usbh_irq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] OFS_STATUS = 4'h0,
  parameter logic [ADDR_W-1:0] OFS_EN_SET = 4'h4,
  parameter logic [ADDR_W-1:0] OFS_EN_CLR = 4'h8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [31:0]       evt_in,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  localparam word_t SRC = src_mask();

  logic  hit_status, hit_set, hit_clr;
  logic  set_we, clr_we, w1c_we;
  word_t en_q, st_q;

  assign hit_status = (reg_addr == OFS_STATUS);
  assign hit_set    = (reg_addr == OFS_EN_SET);
  assign hit_clr    = (reg_addr == OFS_EN_CLR);
  assign set_we     = reg_wr & hit_set;
  assign clr_we     = reg_wr & hit_clr;
  assign w1c_we     = reg_wr & hit_status;

  usbh_irq_enable_store u_en (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .set_we(set_we), .clr_we(clr_we), .wdata(reg_wdata), .en_q(en_q)
  );

  usbh_irq_status_reg u_st (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .w1c_we(w1c_we), .wdata(reg_wdata), .evt(evt_in), .st_q(st_q)
  );

  usbh_irq_gate u_gate (
    .st(st_q), .en(en_q), .irq(irq)
  );

  always_comb begin
    if (hit_status)               reg_rdata = st_q;
    else if (hit_set || hit_clr)  reg_rdata = en_q;
    else                          reg_rdata = '0;
  end

  // R9
  irq_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> en_q[POS_MASTER]);

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((st_q & en_q & SRC) != '0));

  // R11
  unmapped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !hit_status && !hit_set && !hit_clr && !soft_rst && ((evt_in & SRC) == '0))
      |=> ($stable(en_q) && $stable(st_q)));
endmodule

// File: tb/test_usbh_irq_ctrl.sv
module test_usbh_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] evt_in = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  usbh_irq_ctrl i_usbh_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .evt_in(evt_in),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // {offset, write data, expected enable store afterwards}
  localparam logic [67:0] VEC [0:7] = '{
    {4'h4, 32'h0000_007E, 32'h8000_007E},  // R3
    {4'h8, 32'h0000_000A, 32'h8000_0074},  // R2
    {4'h4, 32'hFFFF_FFFF, 32'hC000_007E},  // R3 R5
    {4'h8, 32'h0000_0000, 32'hC000_007E},  // R2 zeros ignored
    {4'h8, 32'h8000_0000, 32'h4000_007E},  // R2 master off
    {4'hC, 32'hFFFF_FFFF, 32'h4000_007E},  // R11
    {4'h4, 32'h8000_0000, 32'hC000_007E},  // R3 master on
    {4'h8, 32'h3FFF_FF81, 32'hC000_007E}   // R5 reserved clears ignored
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests = tests + 1;
    if (got !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk);
    evt_in = v;
    @(negedge clk);
    evt_in = '0;
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    rd(4'h4, r); check("R1 enable reset", r, 32'h8000_0000);
    rd(4'h0, r); check("R1 status reset", r, 32'h0);
    check("R1 irq reset", {31'd0, irq}, 32'h0);

    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][67:64], VEC[i][63:32]);
      rd(4'h4, r); check("R2 R3 R5 R11 enable via set alias", r, VEC[i][31:0]);
      rd(4'h8, r); check("R4 enable via clear alias", r, VEC[i][31:0]);
    end

    // R6 event sets status, R8 irq follows
    pulse(32'h0000_0004);
    rd(4'h0, r); check("R6 event sets status", r, 32'h0000_0004);
    check("R8 irq with master and source on", {31'd0, irq}, 32'h1);

    // R9 master off blocks
    wr(4'h8, 32'h8000_0000);
    check("R9 irq with master off", {31'd0, irq}, 32'h0);
    rd(4'h0, r); check("R9 status retained", r, 32'h0000_0004);
    wr(4'h4, 32'h8000_0000);
    check("R8 irq after master restored", {31'd0, irq}, 32'h1);

    // R8 source enable off
    wr(4'h8, 32'h0000_0004);
    check("R8 irq with source enable off", {31'd0, irq}, 32'h0);

    // R6 w1c zero ignored, then clear
    wr(4'h0, 32'h0000_0000);
    rd(4'h0, r); check("R6 zero write keeps status", r, 32'h0000_0004);
    wr(4'h0, 32'h0000_0004);
    rd(4'h0, r); check("R6 write-1 clears status", r, 32'h0);

    // R7 event and clear in the same cycle
    @(negedge clk);
    evt_in = 32'h0000_0020; reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h0000_0020;
    @(negedge clk);
    evt_in = '0; reg_wr = 1'b0; reg_wdata = '0;
    rd(4'h0, r); check("R7 set wins over clear", r, 32'h0000_0020);
    check("R8 irq from frame overflow", {31'd0, irq}, 32'h1);

    // R5 reserved events ignored
    pulse(32'h8000_0401);
    rd(4'h0, r); check("R5 reserved events ignored", r, 32'h0000_0020);

    // R6 ownership change at bit 30
    pulse(32'h4000_0000);
    rd(4'h0, r); check("R6 ownership change status", r, 32'h4000_0020);

    // R11 unmapped read
    rd(4'hC, r); check("R11 unmapped read zero", r, 32'h0);

    // R10 soft reset
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    rd(4'h4, r); check("R10 enable after soft reset", r, 32'h8000_0000);
    rd(4'h0, r); check("R10 status after soft reset", r, 32'h0);
    check("R10 irq after soft reset", {31'd0, irq}, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule